// File: doc/BRIEF.md
# Clock Output Power Management Controller

This block is the digital control for a clock source with four differential output pairs and one single-ended reference output. It sits between the board-level control pins and the output drivers. It decides, once per cycle of its internal clock, whether each output pair runs or is held low, and whether the reference output runs, is held low, or floats.

A single active-high power-good input doubles as the power-down control. The first time it goes high after a device power-on reset, the block captures two configuration straps:

- **Address select.** Picks one of two 7-bit serial management bus addresses.
- **Spread select.** A three-level pin, presented as a 2-bit code, that picks the spread-spectrum depth requested from the PLL.

Later power-down and power-up cycles leave the captured values untouched. Each output pair runs only when all of the following hold:

- power is good;
- the PLL reports lock;
- the software enable bit for that pair is 1;
- the active-low pin enable for that pair is 0.

The reference output floats until the first power-up. After that it is driven low during every power-down phase.

Top module: `clk_out_pm`

## Requirements
- R1: The straps are captured at the first rising clock edge at which `pwrOk` is 1 after `rstPorN` is released, and `strapsTaken` goes to 1 at that edge. Later power-down and power-up cycles never re-capture them. Only `rstPorN` clears them.
- R2: The captured address select sets bit 1 of `busAddr`. A value of 0 gives 7'b1101000 (0x68) and a value of 1 gives 7'b1101010 (0x6A). `busAddr` is 0x68 while nothing has been captured.
- R3: `spreadMode` decodes the captured `spreadCode` as follows. Code 2'b00 (pin low) gives 2'b00 (spread off). Code 2'b01 (pin mid) gives 2'b01 (-0.25%). Code 2'b10 (pin high) gives 2'b10 (-0.5%). Code 2'b11 gives 2'b00 (off). The output reads 2'b00 before the first capture.
- R4: When `pwrOk` is 0, every bit of `difRun` is 0 after the next rising edge, whatever `oeRegBit`, `oePinN` and `pllLocked` hold. A 0 bit means both the true and complement outputs of that pair are held low.
- R5: `refState` uses three codes: 2'b00 for high-impedance, 2'b01 for driven low and 2'b10 for running. It is 2'b00 from reset until the first edge with `pwrOk` = 1. It is 2'b10 after any edge with `pwrOk` = 1. It is 2'b01 after an edge with `pwrOk` = 0 once power has been good at least once.
- R6: With `pwrOk` = 1 and `pllLocked` = 1, `difRun[i]` becomes 1 after the next rising edge only if `oeRegBit[i]` = 1 and `oePinN[i]` = 0. Otherwise it becomes 0. A change in the inputs shows on the output only at the following rising edge, never between edges.
- R7: While `pllLocked` is 0, every bit of `difRun` is 0 after the next rising edge.
- R8: While `rstPorN` is 0, the outputs take these values: `difRun` = 0, `refState` = 2'b00, `strapsTaken` = 0, `busAddr` = 0x68, `spreadMode` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal control clock |
| rstPorN | input | 1 | Device power-on reset, active low, asynchronous |
| pwrOk | input | 1 | Power good when 1; power-down request when 0 |
| pllLocked | input | 1 | PLL lock indication |
| addrSelPin | input | 1 | Address select strap |
| spreadCode | input | 2 | Spread select strap code (00 low, 01 mid, 10 high, 11 off) |
| oePinN | input | 4 | Per-pair enable pins, active low |
| oeRegBit | input | 4 | Per-pair software enable bits, active high |
| busAddr | output | 7 | Selected 7-bit management bus address |
| spreadMode | output | 2 | Requested spread depth (00 off, 01 -0.25%, 10 -0.5%) |
| strapsTaken | output | 1 | Straps have been captured since power-on reset |
| difRun | output | 4 | Per-pair run flag; 0 holds true and complement low |
| refState | output | 2 | Reference output state (00 Hi-Z, 01 low, 10 run) |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `rstPorN` is the only thing that clears the capture history. The bench changes every input on the falling edge and samples on the next falling edge, so each input value spans a full rising edge. It reaches each fresh-capture scenario only through a new `rstPorN` pulse.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  typedef enum logic [1:0] {
    REF_HIZ = 2'b00,
    REF_LOW = 2'b01,
    REF_RUN = 2'b10
  } refSt_e;

  typedef enum logic [1:0] {
    SPR_OFF     = 2'b00,
    SPR_QUARTER = 2'b01,
    SPR_HALF    = 2'b10
  } spread_e;

  typedef struct packed {
    logic latchNow;  // capture straps this cycle
    logic pwrOn;     // power good this cycle
    logic everUp;    // power has been good since reset
  } cpmStrobe_t;

  function automatic spread_e decodeSpread(input logic [1:0] code);
    case (code)
      2'b01:   return SPR_QUARTER;
      2'b10:   return SPR_HALF;
      default: return SPR_OFF;
    endcase
  endfunction

endpackage

// File: rtl/cpm_ctrl.sv
module cpm_ctrl
  import cpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       pwrOk,
  output cpmStrobe_t strobe
);

  logic everUp;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      everUp <= 1'b0;
    end else if (pwrOk) begin
      everUp <= 1'b1;
    end
  end

  always_comb begin
    strobe.pwrOn    = pwrOk;
    strobe.everUp   = everUp;
    strobe.latchNow = pwrOk && !everUp;
  end

  // R1: once power has been good, the history flag never drops without reset
  p_sticky_history_r1: assert property (@(posedge clk) disable iff (!rstPorN)
    everUp |=> everUp);

  // R1: the first power-good edge always sets the history flag
  p_first_up_marks_r1: assert property (@(posedge clk) disable iff (!rstPorN)
    pwrOk |=> everUp);

endmodule

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int         NUM_OUT      = 4,
  parameter int         ADDR_W       = 7,
  parameter int         ADDR_SEL_BIT = 1,
  parameter logic [6:0] BASE_ADDR    = 7'b1101000
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  cpmStrobe_t         strobe,
  input  logic               pllLocked,
  input  logic               addrSelPin,
  input  logic [1:0]         spreadCode,
  input  logic [NUM_OUT-1:0] oePinN,
  input  logic [NUM_OUT-1:0] oeRegBit,
  output logic [ADDR_W-1:0]  busAddr,
  output spread_e            spreadMode,
  output logic [NUM_OUT-1:0] difRun,
  output refSt_e             refState
);

  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(1) << ADDR_SEL_BIT;

  logic addrSelQ;

  // strap capture
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      addrSelQ   <= 1'b0;
      spreadMode <= SPR_OFF;
    end else if (strobe.latchNow) begin
      addrSelQ   <= addrSelPin;
      spreadMode <= decodeSpread(spreadCode);
    end
  end

  assign busAddr = addrSelQ ? (ADDR_W'(BASE_ADDR) | SEL_MASK) : ADDR_W'(BASE_ADDR);

  // per-pair run gating, registered so a start lands on a clock edge
  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_pair
    always_ff @(posedge clk or negedge rstPorN) begin
      if (!rstPorN) begin
        difRun[gi] <= 1'b0;
      end else begin
        difRun[gi] <= strobe.pwrOn && pllLocked && oeRegBit[gi] && !oePinN[gi];
      end
    end

    // R6: a running pair had both enables asserted at the previous edge
    p_gate_enables_r6: assert property (@(posedge clk) disable iff (!rstPorN)
      difRun[gi] |-> $past(oeRegBit[gi] && !oePinN[gi]));
  end

  // reference output state
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      refState <= REF_HIZ;
    end else if (strobe.pwrOn) begin
      refState <= REF_RUN;
    end else begin
      refState <= strobe.everUp ? REF_LOW : REF_HIZ;
    end
  end

  // R4: power-down forces every pair low at the next edge
  p_pd_all_low_r4: assert property (@(posedge clk) disable iff (!rstPorN)
    !strobe.pwrOn |=> (difRun == '0));

  // R7: no pair runs without lock
  p_nolock_low_r7: assert property (@(posedge clk) disable iff (!rstPorN)
    !pllLocked |=> (difRun == '0));

  // R5: high-impedance is only possible before the first power-up
  p_hiz_before_up_r5: assert property (@(posedge clk) disable iff (!rstPorN)
    strobe.everUp |-> (refState != REF_HIZ));

  // R1: captured straps do not move after the capture
  p_straps_frozen_r1: assert property (@(posedge clk) disable iff (!rstPorN)
    (strobe.everUp && $past(strobe.everUp)) |-> ($stable(busAddr) && $stable(spreadMode)));

  // R3: the decoder never yields the unused code
  p_spread_legal_r3: assert property (@(posedge clk) disable iff (!rstPorN)
    spreadMode != 2'b11);

endmodule

// File: rtl/clk_out_pm.sv
module clk_out_pm
  import cpm_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int ADDR_W  = 7
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  logic               pwrOk,
  input  logic               pllLocked,
  input  logic               addrSelPin,
  input  logic [1:0]         spreadCode,
  input  logic [NUM_OUT-1:0] oePinN,
  input  logic [NUM_OUT-1:0] oeRegBit,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [1:0]         spreadMode,
  output logic               strapsTaken,
  output logic [NUM_OUT-1:0] difRun,
  output logic [1:0]         refState
);

  cpmStrobe_t strobe;
  spread_e    spreadQ;
  refSt_e     refQ;

  cpm_ctrl u_ctrl (
    .clk     (clk),
    .rstPorN (rstPorN),
    .pwrOk   (pwrOk),
    .strobe  (strobe)
  );

  cpm_datapath #(
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstPorN    (rstPorN),
    .strobe     (strobe),
    .pllLocked  (pllLocked),
    .addrSelPin (addrSelPin),
    .spreadCode (spreadCode),
    .oePinN     (oePinN),
    .oeRegBit   (oeRegBit),
    .busAddr    (busAddr),
    .spreadMode (spreadQ),
    .difRun     (difRun),
    .refState   (refQ)
  );

  assign spreadMode  = spreadQ;
  assign refState    = refQ;
  assign strapsTaken = strobe.everUp;

endmodule

// File: tb/clk_out_pm_tb_top.sv
module clk_out_pm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rstPorN;
  logic       pwrOk;
  logic       pllLocked;
  logic       addrSelPin;
  logic [1:0] spreadCode;
  logic [3:0] oePinN;
  logic [3:0] oeRegBit;
  logic [6:0] busAddr;
  logic [1:0] spreadMode;
  logic       strapsTaken;
  logic [3:0] difRun;
  logic [1:0] refState;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_out_pm dut_i (
    .clk         (clk),
    .rstPorN     (rstPorN),
    .pwrOk       (pwrOk),
    .pllLocked   (pllLocked),
    .addrSelPin  (addrSelPin),
    .spreadCode  (spreadCode),
    .oePinN      (oePinN),
    .oeRegBit    (oeRegBit),
    .busAddr     (busAddr),
    .spreadMode  (spreadMode),
    .strapsTaken (strapsTaken),
    .difRun      (difRun),
    .refState    (refState)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one rising edge passes; sampling happens at the following falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstPorN    = 1'b0;
    pwrOk      = 1'b0;
    pllLocked  = 1'b0;
    addrSelPin = 1'b0;
    spreadCode = 2'b00;
    oePinN     = 4'b0000;
    oeRegBit   = 4'b1111;
    step();
    rstPorN = 1'b1;
    step();
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rstPorN = 1'b0;
    pwrOk   = 1'b1;
    #1;
    chk("R8 difRun",      32'(difRun),      32'h0);
    chk("R8 refState",    32'(refState),    32'h0);
    chk("R8 strapsTaken", 32'(strapsTaken), 32'h0);
    chk("R8 busAddr",     32'(busAddr),     32'h68);
    chk("R8 spreadMode",  32'(spreadMode),  32'h0);
    doReset();
    chk("R5 hiz before power up", 32'(refState), 32'h0);
  endtask

  task automatic t_first_capture();
    doReset();
    addrSelPin = 1'b1;
    spreadCode = 2'b10;
    pwrOk      = 1'b1;
    pllLocked  = 1'b1;
    step();
    chk("R1 strapsTaken",      32'(strapsTaken), 32'h1);
    chk("R2 addr sel high",    32'(busAddr),     32'h6A);
    chk("R3 spread high",      32'(spreadMode),  32'h2);
    chk("R5 ref runs",         32'(refState),    32'h2);
    chk("R6 all pairs run",    32'(difRun),      32'hF);
  endtask

  task automatic t_power_cycle();
    // continues from t_first_capture
    addrSelPin = 1'b0;
    spreadCode = 2'b01;
    pwrOk      = 1'b0;
    step();
    chk("R4 pd forces low", 32'(difRun),   32'h0);
    chk("R5 ref low in pd", 32'(refState), 32'h1);
    pwrOk = 1'b1;
    step();
    chk("R1 addr not resampled",   32'(busAddr),    32'h6A);
    chk("R1 spread not resampled", 32'(spreadMode), 32'h2);
    chk("R5 ref runs again",       32'(refState),   32'h2);
    chk("R6 pairs run again",      32'(difRun),     32'hF);
  endtask

  task automatic t_enable_mix();
    oeRegBit = 4'b1011;
    oePinN   = 4'b0110;
    #1;
    chk("R6 no change between edges", 32'(difRun), 32'hF);
    step();
    chk("R6 mix a", 32'(difRun), 32'h9);
    oeRegBit = 4'b0101;
    oePinN   = 4'b0000;
    step();
    chk("R6 mix b", 32'(difRun), 32'h5);
    oeRegBit = 4'b1111;
    oePinN   = 4'b1111;
    step();
    chk("R6 pins off", 32'(difRun), 32'h0);
    oePinN = 4'b0000;
    pwrOk  = 1'b0;
    step();
    chk("R4 pd with all enabled", 32'(difRun), 32'h0);
    pwrOk = 1'b1;
    step();
  endtask

  task automatic t_lock_gate();
    pllLocked = 1'b0;
    step();
    chk("R7 unlocked low", 32'(difRun), 32'h0);
    chk("R7 ref unaffected", 32'(refState), 32'h2);
    pllLocked = 1'b1;
    step();
    chk("R7 relock runs", 32'(difRun), 32'hF);
  endtask

  task automatic t_spread_code(input logic [1:0] code, input logic [1:0] exp, input logic sel);
    doReset();
    spreadCode = code;
    addrSelPin = sel;
    step();
    chk("R1 no capture without pwrOk", 32'(strapsTaken), 32'h0);
    chk("R7 no run before lock", 32'(difRun), 32'h0);
    pwrOk = 1'b1;
    step();
    chk("R3 spread decode", 32'(spreadMode), 32'(exp));
    chk("R2 address", 32'(busAddr), sel ? 32'h6A : 32'h68);
    chk("R7 still no lock", 32'(difRun), 32'h0);
  endtask

  initial begin
    rstPorN    = 1'b0;
    pwrOk      = 1'b0;
    pllLocked  = 1'b0;
    addrSelPin = 1'b0;
    spreadCode = 2'b00;
    oePinN     = 4'b0000;
    oeRegBit   = 4'b1111;
    t_reset_state();
    t_first_capture();
    t_power_cycle();
    t_enable_mix();
    t_lock_gate();
    t_spread_code(2'b00, 2'b00, 1'b0);
    t_spread_code(2'b01, 2'b01, 1'b1);
    t_spread_code(2'b11, 2'b00, 1'b0);
    doReset();
    chk("R1 reset clears capture", 32'(strapsTaken), 32'h0);
    chk("R5 reset returns hiz",    32'(refState),    32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule